// File: doc/BRIEF.md
# Segmented Word Stack Engine

This block performs word-sized push and pop operations against a memory that is only one byte wide. It holds a segment register and an offset (stack pointer) register. Every memory address it issues is built by shifting the segment left by four bits and adding the offset, with the result kept to 20 bits. Each 16-bit word travels as two byte accesses, one after the other. The byte with the smaller address carries the less significant half.

A client raises a push or pop request for one cycle while the engine is idle. The engine reports `busy` while it steps through the byte accesses. It raises `done` for one cycle when the operation has finished. Software-visible setup is limited to loading the segment and the offset directly, and that is allowed only while idle.

The engine knows only where the top of the stack is. It knows nothing of the stack's extent, so running past either end simply wraps the pointer.

Top module: `seg_word_stack`

## Requirements
- R1: After reset the segment and offset read 0000h, `pop_data` reads 0000h, and `busy`, `done` and `mem_en` are low.
- R2: Every byte access drives `mem_addr` = (segment × 16 + access offset) mod 2^20.
- R3: An accepted push first lowers the offset by 2. It then writes two bytes with `mem_we` high, in consecutive cycles: first bits 7:0 at the new offset, then bits 15:8 at the new offset + 1.
- R4: An accepted pop reads the byte at the offset and then the byte at offset + 1, in consecutive cycles. It returns {second byte, first byte} on `pop_data`, and only after both reads does it raise the offset by 2.
- R5: The stack is last-in first-out. After pushing 2345h and then 0132h, the next two pops return 0132h and then 2345h.
- R6: Offset arithmetic wraps modulo 2^16, including the +1 of the upper byte. There is no overflow or underflow detection.
- R7: Latency and handshake:
  - A request is sampled on a clock edge while idle, and `busy` is high from the next cycle.
  - `done` rises in the cycle `busy` falls: 3 cycles after the sampling edge for a push, 4 for a pop. `done` stays high for exactly one cycle.
  - Requests made while `busy` is high are dropped.
- R8: The segment load (`ld_seg`) and offset load (`ld_ofs`) take `ld_val` on the next edge when the engine is idle. Both are ignored while `busy` is high. When a load and a request arrive in the same idle cycle, the load wins and the request is dropped.
- R9: When push and pop are requested in the same idle cycle, the push is performed and the pop is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Request a word push |
| pop_req | input | 1 | Request a word pop |
| push_data | input | 16 | Word to push, sampled with the request |
| pop_data | output | 16 | Last popped word, valid from `done` |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_seg | input | 1 | Load the segment register from `ld_val` |
| ld_ofs | input | 1 | Load the offset register from `ld_val` |
| ld_val | input | 16 | Value for the register loads |
| top_seg | output | 16 | Current segment register |
| top_ofs | output | 16 | Current offset (top-of-stack pointer) |
| mem_en | output | 1 | Byte access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after a read access |

## Verification
A wrong byte lane counter or sequencer state shows up on the memory port within the same operation, as a swapped byte order, a repeated address or a missing write strobe. It also shows up at `done` as a latency of other than three or four cycles. A wrong pointer update is visible on `top_ofs` one cycle after the accepting edge for a push, or in the `done` cycle for a pop. It reappears as a wrong word on the following pop, which the last-in first-out vector sequence exposes within two operations. Wrap errors appear only on the address bus, so the corner tests compare the exact physical byte addresses written near offset 0000h and near the top of the 20-bit space.

// File: rtl/segstk_pkg.sv
package segstk_pkg;

   // Sequencer states of the word stack engine
   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_PUSH     = 2'd1,
      ST_POP_RD   = 2'd2,
      ST_POP_TAIL = 2'd3
   } seq_state_t;

endpackage

// File: rtl/segstk_addr.sv
// Physical address former: (segment << shift) + (offset + bias), truncated.
module segstk_addr #(
   parameter int SEG_W     = 16,
   parameter int OFS_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int PHYS_W    = 20,
   parameter int BIAS_W    = 1
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [BIAS_W-1:0] bias,
   output logic [PHYS_W-1:0] phys
);

   logic [OFS_W-1:0]  eff_ofs;
   logic [PHYS_W-1:0] seg_base;

   // the byte offset wraps inside the segment before the base is added
   assign eff_ofs = ofs + OFS_W'(bias);

   generate
      if (SEG_SHIFT == 0) begin : g_flat
         assign seg_base = PHYS_W'(seg);
      end else begin : g_shifted
         assign seg_base = PHYS_W'(seg) << SEG_SHIFT;
      end
   endgenerate

   assign phys = seg_base + PHYS_W'(eff_ofs);

endmodule

// File: rtl/segstk_ptr.sv
// Segment and offset registers with direct load and word stepping.
module segstk_ptr #(
   parameter int SEG_W = 16,
   parameter int OFS_W = 16,
   parameter int LD_W  = 16,
   parameter int STEP  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_ok,
   input  logic             ld_seg,
   input  logic             ld_ofs,
   input  logic [LD_W-1:0]  ld_val,
   input  logic             step_dn,
   input  logic             step_up,
   output logic [SEG_W-1:0] seg_q,
   output logic [OFS_W-1:0] ofs_q
);

   localparam logic [OFS_W-1:0] STEP_V = OFS_W'(STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q <= '0;
      end else if (ld_seg && load_ok) begin
         seg_q <= ld_val[SEG_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q <= '0;
      end else if (ld_ofs && load_ok) begin
         ofs_q <= ld_val[OFS_W-1:0];
      end else if (step_dn) begin
         ofs_q <= ofs_q - STEP_V;
      end else if (step_up) begin
         ofs_q <= ofs_q + STEP_V;
      end
   end

endmodule

// File: rtl/segstk_seq.sv
// Sequencer: turns one word operation into NBYTES ordered byte accesses.
module segstk_seq
   import segstk_pkg::*;
#(
   parameter int NBYTES = 2,
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push_req,
   input  logic                     pop_req,
   input  logic                     ld_any,
   input  logic [NBYTES*BYTE_W-1:0] push_data,
   input  logic [BYTE_W-1:0]        mem_rdata,
   output logic [NBYTES*BYTE_W-1:0] pop_data,
   output logic                     busy,
   output logic                     done,
   output logic                     load_ok,
   output logic                     step_dn,
   output logic                     step_up,
   output logic [IDX_W-1:0]         lane_idx,
   output logic                     mem_en,
   output logic                     mem_we,
   output logic [BYTE_W-1:0]        mem_wdata
);

   localparam int               WORD_W = NBYTES * BYTE_W;
   localparam logic [IDX_W-1:0] LAST   = IDX_W'(NBYTES - 1);

   seq_state_t        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic              done_q;
   logic [WORD_W-1:0] wr_buf_q;
   logic              start_push;
   logic              start_pop;
   logic              cap_en;
   logic [IDX_W-1:0]  cap_lane;
   logic [BYTE_W-1:0] wr_lane [NBYTES];
   logic [BYTE_W-1:0] rd_lane_q [NBYTES];

   assign load_ok    = (state_q == ST_IDLE);
   assign start_push = load_ok && !ld_any && push_req;
   assign start_pop  = load_ok && !ld_any && !push_req && pop_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         idx_q    <= '0;
         done_q   <= 1'b0;
         wr_buf_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               idx_q <= '0;
               if (start_push) begin
                  wr_buf_q <= push_data;
                  state_q  <= ST_PUSH;
               end else if (start_pop) begin
                  state_q <= ST_POP_RD;
               end
            end
            ST_PUSH: begin
               if (idx_q == LAST) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  idx_q   <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_POP_RD: begin
               if (idx_q == LAST) begin
                  state_q <= ST_POP_TAIL;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_POP_TAIL: begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
               idx_q   <= '0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // pointer moves: before a push, after the last read of a pop
   assign step_dn  = start_push;
   assign step_up  = (state_q == ST_POP_TAIL);

   assign busy     = !load_ok;
   assign done     = done_q;
   assign lane_idx = idx_q;
   assign mem_en   = (state_q == ST_PUSH) || (state_q == ST_POP_RD);
   assign mem_we   = (state_q == ST_PUSH);

   // read data arrives one cycle after its access
   assign cap_en   = ((state_q == ST_POP_RD) && (idx_q != '0)) ||
                     (state_q == ST_POP_TAIL);
   assign cap_lane = (state_q == ST_POP_TAIL) ? LAST : (idx_q - 1'b1);

   generate
      for (genvar j = 0; j < NBYTES; j++) begin : g_lane
         assign wr_lane[j] = wr_buf_q[j*BYTE_W +: BYTE_W];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_lane_q[j] <= '0;
            end else if (cap_en && (cap_lane == IDX_W'(j))) begin
               rd_lane_q[j] <= mem_rdata;
            end
         end

         assign pop_data[j*BYTE_W +: BYTE_W] = rd_lane_q[j];
      end
   endgenerate

   assign mem_wdata = wr_lane[idx_q];

endmodule

// File: rtl/seg_word_stack.sv
// Segmented word stack engine over a byte-wide synchronous memory.
module seg_word_stack #(
   parameter int DATA_W    = 16,
   parameter int BYTE_W    = 8,
   parameter int SEG_W     = 16,
   parameter int OFS_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int PHYS_W    = 20,
   localparam int LD_W     = (SEG_W > OFS_W) ? SEG_W : OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic [DATA_W-1:0] push_data,
   output logic [DATA_W-1:0] pop_data,
   output logic              busy,
   output logic              done,
   input  logic              ld_seg,
   input  logic              ld_ofs,
   input  logic [LD_W-1:0]   ld_val,
   output logic [SEG_W-1:0]  top_seg,
   output logic [OFS_W-1:0]  top_ofs,
   output logic              mem_en,
   output logic              mem_we,
   output logic [PHYS_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata
);

   localparam int NBYTES = DATA_W / BYTE_W;
   localparam int IDX_W  = (NBYTES > 2) ? $clog2(NBYTES) : 1;

   generate
      if ((DATA_W % BYTE_W) != 0 || NBYTES < 2) begin : g_bad_word
         $error("seg_word_stack: DATA_W must be a multiple (>=2) of BYTE_W");
      end
      if (PHYS_W < OFS_W) begin : g_bad_phys
         $error("seg_word_stack: PHYS_W must cover the offset width");
      end
      if (NBYTES >= (1 << OFS_W)) begin : g_bad_step
         $error("seg_word_stack: word step exceeds offset range");
      end
   endgenerate

   logic             load_ok;
   logic             step_dn;
   logic             step_up;
   logic [IDX_W-1:0] lane_idx;

   segstk_seq #(
      .NBYTES (NBYTES),
      .BYTE_W (BYTE_W),
      .IDX_W  (IDX_W)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (push_req),
      .pop_req   (pop_req),
      .ld_any    (ld_seg || ld_ofs),
      .push_data (push_data),
      .mem_rdata (mem_rdata),
      .pop_data  (pop_data),
      .busy      (busy),
      .done      (done),
      .load_ok   (load_ok),
      .step_dn   (step_dn),
      .step_up   (step_up),
      .lane_idx  (lane_idx),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata)
   );

   segstk_ptr #(
      .SEG_W (SEG_W),
      .OFS_W (OFS_W),
      .LD_W  (LD_W),
      .STEP  (NBYTES)
   ) i_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_ok (load_ok),
      .ld_seg  (ld_seg),
      .ld_ofs  (ld_ofs),
      .ld_val  (ld_val),
      .step_dn (step_dn),
      .step_up (step_up),
      .seg_q   (top_seg),
      .ofs_q   (top_ofs)
   );

   segstk_addr #(
      .SEG_W     (SEG_W),
      .OFS_W     (OFS_W),
      .SEG_SHIFT (SEG_SHIFT),
      .PHYS_W    (PHYS_W),
      .BIAS_W    (IDX_W)
   ) i_addr (
      .seg  (top_seg),
      .ofs  (top_ofs),
      .bias (lane_idx),
      .phys (mem_addr)
   );

endmodule

// File: rtl/segstk_chk.sv
// Port-level protocol checker, bound to the engine.
module segstk_chk #(
   parameter int SEG_W = 16,
   parameter int OFS_W = 16,
   parameter int STEP  = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             push_req,
   input logic             busy,
   input logic             done,
   input logic             mem_en,
   input logic             mem_we,
   input logic             ld_seg,
   input logic [SEG_W-1:0] top_seg,
   input logic [OFS_W-1:0] top_ofs
);

   localparam logic [OFS_W-1:0] STEP_V = OFS_W'(STEP);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R7

   AST_MEM_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> busy); // R7

   AST_WE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && $past(mem_en)) |-> (mem_we == $past(mem_we))); // R3

   AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && $past(push_req)) |-> (top_ofs == $past(top_ofs) - STEP_V)); // R3

   AST_POP_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(mem_we)) |-> (top_ofs == $past(top_ofs) + STEP_V)); // R4

   AST_OFS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$rose(busy)) |-> $stable(top_ofs)); // R8

   AST_SEG_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(top_seg) |-> ($past(ld_seg) && !$past(busy))); // R8

endmodule

bind seg_word_stack segstk_chk #(
   .SEG_W (SEG_W),
   .OFS_W (OFS_W),
   .STEP  (DATA_W / BYTE_W)
) i_segstk_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .push_req (push_req),
   .busy     (busy),
   .done     (done),
   .mem_en   (mem_en),
   .mem_we   (mem_we),
   .ld_seg   (ld_seg),
   .top_seg  (top_seg),
   .top_ofs  (top_ofs)
);

// File: tb/test_seg_word_stack.sv
module test_seg_word_stack;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_req = 1'b0;
   logic        pop_req = 1'b0;
   logic [15:0] push_data = '0;
   logic [15:0] pop_data;
   logic        busy;
   logic        done;
   logic        ld_seg = 1'b0;
   logic        ld_ofs = 1'b0;
   logic [15:0] ld_val = '0;
   logic [15:0] top_seg;
   logic [15:0] top_ofs;
   logic        mem_en;
   logic        mem_we;
   logic [19:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;

   int n_chk  = 0;
   int n_fail = 0;

   logic [7:0]  mem [int];
   logic [19:0] wprev = '0, wlast = '0, rprev = '0, rlast = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_word_stack i_seg_word_stack (
      .clk, .rst_n, .push_req, .pop_req, .push_data, .pop_data, .busy, .done,
      .ld_seg, .ld_ofs, .ld_val, .top_seg, .top_ofs,
      .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata
   );

   // byte memory model with one-cycle read latency
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            mem[int'(mem_addr)] = mem_wdata;
            wprev <= wlast;
            wlast <= mem_addr;
         end else begin
            mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
            rprev <= rlast;
            rlast <= mem_addr;
         end
      end
   end

   function automatic logic [7:0] peek(input int a);
      return mem.exists(a) ? mem[a] : 8'h00;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // op: 1 push, 2 pop, 3 both in the same cycle
   task automatic run_op(input logic [1:0] op, input logic [15:0] d, output int cyc);
      @(negedge clk);
      push_req  = op[0];
      pop_req   = op[1];
      push_data = d;
      @(negedge clk);
      push_req = 1'b0;
      pop_req  = 1'b0;
      cyc = 1;
      while (!done && cyc < 20) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic load(input logic is_seg, input logic [15:0] v);
      @(negedge clk);
      ld_seg = is_seg;
      ld_ofs = !is_seg;
      ld_val = v;
      @(negedge clk);
      ld_seg = 1'b0;
      ld_ofs = 1'b0;
   endtask

   // op(2) data(16) offset after(16) expected popped word(16); segment 1000h
   localparam logic [49:0] VEC [0:9] = '{
      {2'd1, 16'h2345, 16'h000E, 16'h0000},
      {2'd1, 16'h0132, 16'h000C, 16'h0000},
      {2'd2, 16'h0000, 16'h000E, 16'h0132},
      {2'd2, 16'h0000, 16'h0010, 16'h2345},
      {2'd1, 16'hA5C3, 16'h000E, 16'h0000},
      {2'd1, 16'h00FF, 16'h000C, 16'h0000},
      {2'd2, 16'h0000, 16'h000E, 16'h00FF},
      {2'd1, 16'h7E81, 16'h000C, 16'h0000},
      {2'd2, 16'h0000, 16'h000E, 16'h7E81},
      {2'd2, 16'h0000, 16'h0010, 16'hA5C3}
   };

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual expired expected finished");
      report();
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 seg", top_seg, 16'h0);
      chk("R1 ofs", top_ofs, 16'h0);
      chk("R1 busy", busy, 1'b0);
      chk("R1 done", done, 1'b0);
      chk("R1 mem_en", mem_en, 1'b0);
      chk("R1 pop_data", pop_data, 16'h0);

      // R8 loads while idle
      load(1'b1, 16'h1000);
      load(1'b0, 16'h0010);
      chk("R8 seg load", top_seg, 16'h1000);
      chk("R8 ofs load", top_ofs, 16'h0010);

      // vector table: R2 R3 R4 R5 R7
      for (int i = 0; i < 10; i++) begin
         logic [1:0]  op;
         logic [15:0] d, sp, rd;
         {op, d, sp, rd} = VEC[i];
         run_op(op, d, cyc);
         chk("R3/R4 offset", top_ofs, sp);
         if (op == 2'd1) begin
            chk("R7 push latency", cyc, 3);
            chk("R3 low byte first", wprev, 20'h10000 + sp);
            chk("R3 high byte second", wlast, 20'h10000 + sp + 1);
            chk("R2 stored word", {peek(32'h10000 + sp + 1), peek(32'h10000 + sp)}, d);
         end else begin
            chk("R7 pop latency", cyc, 4);
            chk("R4 read order lo", rprev, 20'h10000 + sp - 2);
            chk("R4 read order hi", rlast, 20'h10000 + sp - 1);
            chk("R5 popped word", pop_data, rd);
         end
      end
      @(negedge clk);
      chk("R7 done one cycle", done, 1'b0);

      // R7 / R8: pop request and offset load during a busy push are dropped
      @(negedge clk);
      push_req = 1'b1; push_data = 16'h1111;
      @(negedge clk);
      push_req = 1'b0; pop_req = 1'b1; ld_ofs = 1'b1; ld_val = 16'h5555;
      chk("R7 busy after accept", busy, 1'b1);
      @(negedge clk);
      pop_req = 1'b0; ld_ofs = 1'b0;
      while (!done) @(negedge clk);
      repeat (2) @(negedge clk);
      chk("R7 pop during busy dropped", busy, 1'b0);
      chk("R8 ofs load during busy ignored", top_ofs, 16'h000E);
      chk("R7 word written", {peek(32'h1000F), peek(32'h1000E)}, 16'h1111);

      // R8: load beats a push in the same idle cycle
      @(negedge clk);
      ld_ofs = 1'b1; ld_val = 16'h0040; push_req = 1'b1; push_data = 16'h9999;
      @(negedge clk);
      ld_ofs = 1'b0; push_req = 1'b0;
      chk("R8 load precedence ofs", top_ofs, 16'h0040);
      chk("R8 push dropped", busy, 1'b0);

      // R9: push wins over pop
      run_op(2'd3, 16'h2468, cyc);
      chk("R9 push chosen offset", top_ofs, 16'h003E);
      chk("R9 push latency", cyc, 3);
      chk("R9 push data", {peek(32'h1003F), peek(32'h1003E)}, 16'h2468);

      // R6: offset wrap during push, upper byte at offset 0000
      load(1'b1, 16'h0200);
      load(1'b0, 16'h0001);
      run_op(2'd1, 16'hBEEF, cyc);
      chk("R6 offset wrap down", top_ofs, 16'hFFFF);
      chk("R6 low byte addr", wprev, 20'h11FFF);
      chk("R6 high byte wraps in segment", wlast, 20'h02000);
      run_op(2'd2, 16'h0000, cyc);
      chk("R6 pop after wrap", pop_data, 16'hBEEF);
      chk("R6 offset wrap up", top_ofs, 16'h0001);

      // R2 / R6: physical address wraps modulo 2^20
      load(1'b1, 16'hFFFF);
      load(1'b0, 16'h0022);
      run_op(2'd1, 16'h1234, cyc);
      chk("R2 phys wrap lo", wprev, 20'h00010);
      chk("R2 phys wrap hi", wlast, 20'h00011);
      chk("R2 phys wrap data", {peek(32'h00011), peek(32'h00010)}, 16'h1234);

      // R6: pop past the top, no detection, pointer wraps to 0000
      load(1'b1, 16'h0000);
      load(1'b0, 16'hFFFE);
      run_op(2'd2, 16'h0000, cyc);
      chk("R6 underflow pop data", pop_data, 16'h0000);
      chk("R6 underflow offset", top_ofs, 16'h0000);
      chk("R6 underflow latency", cyc, 4);

      report();
   end

endmodule